// File: doc/BRIEF.md
# Two-Road Traffic Light Sequencer

This block drives the lamps at a junction of two roads, called A and B. It is a Moore state machine with four normal phases. In each phase one road has right of way and the other waits. The phase lasts until an expiry input for that phase is raised by timers outside the block. The four phases are: A red with B green, A red with B yellow, A green with B red, and A yellow with B red.

Reset puts the machine in a holding state where both roads show yellow. Once reset is released, normal cycling starts. A single-cycle start pulse marks each entry into a new state, so that the outside timers can restart their count.

All lamp outputs are decoded from the current state alone. An expiry input only matters while its own phase is active.

Top module: `two_road_signal_fsm`

## Requirements
- R1: Reset (`rst`) is synchronous and active high. After any clock edge at which `rst` is high, both roads show yellow and `phase_start` is low.
- R2: When `rst` is low at a clock edge, the both-yellow state moves to the A-red/B-green phase. It does so whatever the expiry inputs are, and it never skips ahead in the same step.
- R3: A phase is held while its own expiry input is low. The other three expiry inputs have no effect on it.
- R4: A phase advances at the first clock edge at which its own expiry input is high. The order is: A-red/B-green (`done_rg`), then A-red/B-yellow (`done_ry`), then A-green/B-red (`done_gr`), then A-yellow/B-red (`done_yr`), then back to A-red/B-green.
- R5: Exactly one lamp per road is lit in every cycle. The lamp vector is read as {a_red,a_yel,a_grn,b_red,b_yel,b_grn}. Its values are: both-yellow = 010010, A-red/B-green = 100001, A-red/B-yellow = 100010, A-green/B-red = 001100, A-yellow/B-red = 010100.
- R6: `phase_start` is high for exactly the cycle that follows a clock edge at which the state changed without reset. It is low in every other cycle.
- R7: Reset asserted during any phase returns the machine to both-yellow at the next edge. This takes priority over a high expiry input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_rg | input | 1 | Expiry of the A-red/B-green phase |
| done_ry | input | 1 | Expiry of the A-red/B-yellow phase |
| done_gr | input | 1 | Expiry of the A-green/B-red phase |
| done_yr | input | 1 | Expiry of the A-yellow/B-red phase |
| a_red | output | 1 | Road A red lamp |
| a_yel | output | 1 | Road A yellow lamp |
| a_grn | output | 1 | Road A green lamp |
| b_red | output | 1 | Road B red lamp |
| b_yel | output | 1 | Road B yellow lamp |
| b_grn | output | 1 | Road B green lamp |
| phase_start | output | 1 | One-cycle pulse on entry into a new state |

## Verification
The bench holds each phase while the other three expiry inputs are high. A design that decoded the wrong expiry input would advance early.

It leaves reset with all expiries high. A design that chained the transitions would land beyond the A-red/B-green phase.

It raises every expiry input on every cycle, so the machine moves each cycle. A pulse generator built as an edge detector would then drop the back-to-back `phase_start` pulses.

It asserts reset together with a high expiry input in several phases. A design that gave the expiry priority over reset would be caught here, and so would a design that raised `phase_start` on the way into reset.

// File: rtl/two_road_signal_fsm.sv
module two_road_signal_fsm (
  input  logic clk,
  input  logic rst,
  input  logic done_rg,
  input  logic done_ry,
  input  logic done_gr,
  input  logic done_yr,
  output logic a_red,
  output logic a_yel,
  output logic a_grn,
  output logic b_red,
  output logic b_yel,
  output logic b_grn,
  output logic phase_start
);

  typedef enum logic [2:0] {
    S_YY = 3'd0,
    S_RG = 3'd1,
    S_RY = 3'd2,
    S_GR = 3'd3,
    S_YR = 3'd4
  } light_t;

  light_t st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      S_YY: nxt = S_RG;
      S_RG: if (done_rg) nxt = S_RY;
      S_RY: if (done_ry) nxt = S_GR;
      S_GR: if (done_gr) nxt = S_YR;
      S_YR: if (done_yr) nxt = S_RG;
      default: nxt = S_YY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_YY;
      phase_start <= 1'b0;
    end else begin
      st          <= nxt;
      phase_start <= (nxt != st);
    end
  end

  assign a_red = (st == S_RG) || (st == S_RY);
  assign a_grn = (st == S_GR);
  assign a_yel = (st == S_YR) || (st == S_YY);
  assign b_red = (st == S_GR) || (st == S_YR);
  assign b_grn = (st == S_RG);
  assign b_yel = (st == S_RY) || (st == S_YY);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (a_yel && b_yel && !phase_start));

  a_r2_leave_yy: assert property (@(posedge clk) disable iff (rst)
    (a_yel && b_yel) |=> (a_red && b_grn && phase_start));

  a_r3_hold_rg: assert property (@(posedge clk) disable iff (rst)
    (a_red && b_grn && !done_rg) |=> (a_red && b_grn && !phase_start));

  a_r3_hold_gr: assert property (@(posedge clk) disable iff (rst)
    (a_grn && b_red && !done_gr) |=> (a_grn && b_red && !phase_start));

  a_r4_rg_to_ry: assert property (@(posedge clk) disable iff (rst)
    (a_red && b_grn && done_rg) |=> (a_red && b_yel));

  a_r4_yr_to_rg: assert property (@(posedge clk) disable iff (rst)
    (a_yel && b_red && done_yr) |=> (a_red && b_grn));

  a_r5_one_lamp: assert property (@(posedge clk) disable iff (rst)
    ($countones({a_red, a_yel, a_grn}) == 1) && ($countones({b_red, b_yel, b_grn}) == 1));

  a_r6_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
    phase_start |-> (st != $past(st)));

endmodule

// File: tb/sim_two_road_signal_fsm.sv
`timescale 1ns/1ps
module sim_two_road_signal_fsm;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_rg = 1'b0, done_ry = 1'b0, done_gr = 1'b0, done_yr = 1'b0;
  logic a_red, a_yel, a_grn, b_red, b_yel, b_grn, phase_start;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [5:0] q_lamps[$];
  logic       q_start[$];
  string      q_tag[$];

  int m_state = 0;

  always #2.5 clk = ~clk;

  two_road_signal_fsm u0 (
    .clk(clk), .rst(rst),
    .done_rg(done_rg), .done_ry(done_ry), .done_gr(done_gr), .done_yr(done_yr),
    .a_red(a_red), .a_yel(a_yel), .a_grn(a_grn),
    .b_red(b_red), .b_yel(b_yel), .b_grn(b_grn),
    .phase_start(phase_start)
  );

  function automatic logic [5:0] lamps_of(int s);
    case (s)
      1: return 6'b100001;
      2: return 6'b100010;
      3: return 6'b001100;
      4: return 6'b010100;
      default: return 6'b010010;
    endcase
  endfunction

  task automatic step(input logic r, input logic [3:0] d, input string tag);
    int ns;
    logic st_exp;
    @(negedge clk);
    rst = r;
    {done_yr, done_gr, done_ry, done_rg} = d;
    if (r) ns = 0;
    else if (m_state == 0) ns = 1;
    else if (d[m_state-1]) ns = (m_state == 4) ? 1 : m_state + 1;
    else ns = m_state;
    st_exp = !r && (ns != m_state);
    m_state = ns;
    q_lamps.push_back(lamps_of(ns));
    q_start.push_back(st_exp);
    q_tag.push_back(tag);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q_lamps.size() > 0) begin
      logic [5:0] el;
      logic es;
      string t;
      logic [5:0] al;
      el = q_lamps.pop_front();
      es = q_start.pop_front();
      t  = q_tag.pop_front();
      al = {a_red, a_yel, a_grn, b_red, b_yel, b_grn};
      checks++;
      if (al !== el) begin
        errors++;
        $display("FAIL %s lamps actual=%b expected=%b", t, al, el);
      end
      checks++;
      if (phase_start !== es) begin
        errors++;
        $display("FAIL %s phase_start actual=%b expected=%b", t, phase_start, es);
      end
      checks++;
      if ($countones(al[5:3]) != 1 || $countones(al[2:0]) != 1) begin
        errors++;
        $display("FAIL R5 one lamp per road actual=%b expected=one-hot per road", al);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(1'b1, 4'h0, "R1 reset");
    step(1'b1, 4'h0, "R1 reset");
    step(1'b1, 4'hF, "R1 reset with expiries");
    step(1'b0, 4'hF, "R2 leave yy");
    step(1'b0, 4'b1110, "R3 hold rg");
    step(1'b0, 4'b1110, "R3 hold rg");
    step(1'b0, 4'b0001, "R4 rg to ry");
    step(1'b0, 4'b1101, "R3 hold ry");
    step(1'b0, 4'b0010, "R4 ry to gr");
    step(1'b0, 4'b1011, "R3 hold gr");
    step(1'b0, 4'b0100, "R4 gr to yr");
    step(1'b0, 4'b0111, "R3 hold yr");
    step(1'b0, 4'b1000, "R4 yr to rg");
    for (int i = 0; i < 9; i++) step(1'b0, 4'hF, "R6 back to back");
    step(1'b1, 4'hF, "R7 reset over expiry");
    step(1'b0, 4'h0, "R2 leave yy no expiry");
    step(1'b0, 4'h1, "R4 rg to ry");
    step(1'b0, 4'h2, "R4 ry to gr");
    step(1'b1, 4'h4, "R7 reset in gr");
    step(1'b0, 4'h0, "R2 leave yy");
    for (int i = 0; i < 4000; i++) begin
      logic r;
      logic [3:0] d;
      r = ($urandom % 64) == 0;
      d = 4'($urandom) & 4'($urandom);
      step(r, d, r ? "R7 random reset" : "R4 R6 random");
    end
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule